// File: doc/BRIEF.md
# DRAM Refresh Scheduler and Sequencer

This block keeps an asynchronous EDO DRAM array refreshed. A free-running interval counter adds one owed refresh to a small backlog every refresh interval, where the interval is the 64 ms retention window divided by the row count of the part. With 4096 rows the interval is about 15.6 us; with 8192 rows it is about 7.8 us. While refreshes are owed and the block is idle, it raises a request to the access sequencer. It starts a refresh only in a cycle where the sequencer grants the bus. It then drives the RAS, CAS, WE and address lines until the RAS precharge of that refresh is over, and releases the bus.

Three refresh forms are built in. The default form lowers CAS before RAS. The RAS-only form pulses RAS while CAS stays high, with the row from an internal wrapping counter on the address lines. The hidden form is taken when the sequencer reports that CAS is already held low by an open read: RAS is precharged, pulsed low and precharged again, and CAS stays low the whole time. All nanosecond limits are converted to whole clock cycles at elaboration, rounding up.

The backlog saturates at eight owed refreshes. Once it is full, an urgency flag tells the sequencer that the next grant must go to refresh.

Top module: `dram_refresh_ctl`

## Requirements
- R1: The backlog gains one owed refresh every INTERVAL_CYC = WINDOW_NS / ROWS / CLK_NS clock cycles, the first gain coming INTERVAL_CYC cycles after reset. `ref_req` is 1 exactly when the backlog is non-zero and the block is not driving a refresh.
- R2: A refresh starts only on a clock edge where `ref_req` and `acc_grant` are both 1. `bus_own` is 1 from the following cycle until the last precharge cycle ends, and each finished refresh removes one owed refresh.
- R3: In a CAS-before-RAS refresh, `cas_n` goes low SETUP_CYC = max(ceil(CSR), ceil(WSR)) cycles before `ras_n` falls. It stays low for HOLD_CYC = ceil(CHR) cycles with `ras_n` low, and then rises while `ras_n` stays low.
- R4: `we_n` is 1 in every cycle, including the setup cycles before RAS falls and every owned cycle after it. A low WE at the fall of RAS would select test mode.
- R5: When `ras_only_mode` is 1 at the start, the refresh has 1 setup cycle with RAS high, ACT_CYC cycles with RAS low and PRE_CYC precharge cycles. CAS stays high throughout, and `row_addr` carries the internal row for all owned cycles. The row advances by one after each such refresh and wraps from ROWS-1 to 0.
- R6: RAS is low for ACT_CYC = max(ceil(RAS), HOLD_CYC+1) cycles per refresh. Each refresh ends with PRE_CYC = max(ceil(RP), ceil(RC) - ACT_CYC) cycles of RAS high, so that the active time plus the precharge time meets the random-cycle minimum.
- R7: The backlog never exceeds MAX_PEND (8); an interval that expires while it is full is dropped. `ref_urgent` is 1 exactly when the backlog equals MAX_PEND.
- R8: When `hidden_ok` is 1 at the start, the refresh holds `cas_n` low for all owned cycles. `ras_n` is high for PRE_CYC cycles, low for ACT_CYC cycles and high for PRE_CYC cycles, and `row_addr` is 0. This takes precedence over `ras_only_mode`.
- R9: After reset, and in every cycle that is not owned, `ras_n`, `cas_n` and `we_n` are 1 and `row_addr` is 0. After reset `ref_req`, `ref_urgent` and `bus_own` are 0.
- R10: Changes of `ras_only_mode`, `hidden_ok` or `acc_grant` while a refresh is running have no effect on that refresh's waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ras_only_mode | input | 1 | Selects RAS-only refresh for the next start |
| hidden_ok | input | 1 | An open read holds CAS low; the next start is a hidden refresh |
| acc_grant | input | 1 | Bus grant from the access sequencer |
| ref_req | output | 1 | Refresh owed and block idle |
| ref_urgent | output | 1 | Backlog full; refresh must win the next grant |
| bus_own | output | 1 | Block is driving the DRAM control lines |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| row_addr | output | ROW_BITS | Row address for RAS-only refresh |

## Verification
Some properties are checked on every cycle: CAS is already low at any owned RAS fall where CAS is low, RAS low pulses are at least ACT_CYC long, the address is steady while a RAS-only pulse is low, idle lines are inactive, a start always follows a request with a grant, and a full backlog only drops when a refresh finishes. Other behaviour only the bench's scenarios can show, because the cycle-exact reference model is needed to confirm it. This covers the exact interval count, saturation at eight with dropped ticks, the row counter wrapping after sixteen RAS-only refreshes, the hidden waveform with CAS held low, and mode or grant changes during a refresh leaving it untouched.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CBR_SETUP,
    ST_CBR_HOLD,
    ST_CBR_ACT,
    ST_RO_SETUP,
    ST_RO_ACT,
    ST_HID_PRE,
    ST_HID_ACT,
    ST_HID_REL,
    ST_PRE
  } rfsh_state_e;

  // Round a nanosecond limit up to whole clock cycles, never below one.
  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rfsh_interval_tick.sv
module rfsh_interval_tick #(
  parameter int INTERVAL_CYC = 1562
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = $clog2(INTERVAL_CYC + 1);

  logic [CW-1:0] cnt_q;

  assign tick = (cnt_q == CW'(INTERVAL_CYC - 1));

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/rfsh_backlog.sv
module rfsh_backlog #(
  parameter int MAX_PEND = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic add_i,
  input  logic sub_i,
  output logic nonzero_o,
  output logic full_o
);
  localparam int PW = $clog2(MAX_PEND + 1);

  logic [PW-1:0] pend_q;

  assign nonzero_o = (pend_q != '0);
  assign full_o    = (pend_q == PW'(MAX_PEND));

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
    end else if (add_i && !sub_i) begin
      if (!full_o) pend_q <= pend_q + 1'b1;
    end else if (sub_i && !add_i) begin
      if (nonzero_o) pend_q <= pend_q - 1'b1;
    end
  end
endmodule

// File: rtl/rfsh_row_ctr.sv
module rfsh_row_ctr #(
  parameter int ROWS     = 4096,
  parameter int ROW_BITS = $clog2(ROWS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                adv_i,
  output logic [ROW_BITS-1:0] row_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      row_o <= '0;
    end else if (adv_i) begin
      if (row_o == ROW_BITS'(ROWS - 1)) row_o <= '0;
      else                              row_o <= row_o + 1'b1;
    end
  end
endmodule

// File: rtl/rfsh_seq.sv
module rfsh_seq
  import rfsh_pkg::*;
#(
  parameter int ROW_BITS  = 12,
  parameter int SETUP_CYC = 1,
  parameter int HOLD_CYC  = 1,
  parameter int ACT_CYC   = 6,
  parameter int PRE_CYC   = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic                hidden_i,
  input  logic                ras_only_i,
  input  logic [ROW_BITS-1:0] row_i,
  output logic                idle_o,
  output logic                done_o,
  output logic                own_o,
  output logic                ras_n_o,
  output logic                cas_n_o,
  output logic                we_n_o,
  output logic                ro_done_o,
  output logic [ROW_BITS-1:0] addr_o
);
  localparam int LONGEST = imax(imax(SETUP_CYC, HOLD_CYC), imax(ACT_CYC, PRE_CYC));
  localparam int TW      = $clog2(LONGEST + 1);

  rfsh_state_e   st_q, st_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic          ro_q, ro_d;

  assign idle_o    = (st_q == ST_IDLE);
  assign ro_done_o = done_o && ro_q;

  always_comb begin
    st_d   = st_q;
    ro_d   = ro_q;
    tmr_d  = (tmr_q != '0) ? tmr_q - 1'b1 : tmr_q;
    done_o = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          if (hidden_i) begin
            st_d = ST_HID_PRE;   tmr_d = TW'(PRE_CYC - 1);   ro_d = 1'b0;
          end else if (ras_only_i) begin
            st_d = ST_RO_SETUP;  tmr_d = '0;                  ro_d = 1'b1;
          end else begin
            st_d = ST_CBR_SETUP; tmr_d = TW'(SETUP_CYC - 1); ro_d = 1'b0;
          end
        end
      end
      ST_CBR_SETUP: if (tmr_q == '0) begin st_d = ST_CBR_HOLD; tmr_d = TW'(HOLD_CYC - 1); end
      ST_CBR_HOLD:  if (tmr_q == '0) begin st_d = ST_CBR_ACT;  tmr_d = TW'(ACT_CYC - HOLD_CYC - 1); end
      ST_CBR_ACT:   if (tmr_q == '0) begin st_d = ST_PRE;      tmr_d = TW'(PRE_CYC - 1); end
      ST_RO_SETUP:  if (tmr_q == '0) begin st_d = ST_RO_ACT;   tmr_d = TW'(ACT_CYC - 1); end
      ST_RO_ACT:    if (tmr_q == '0) begin st_d = ST_PRE;      tmr_d = TW'(PRE_CYC - 1); end
      ST_HID_PRE:   if (tmr_q == '0) begin st_d = ST_HID_ACT;  tmr_d = TW'(ACT_CYC - 1); end
      ST_HID_ACT:   if (tmr_q == '0) begin st_d = ST_HID_REL;  tmr_d = TW'(PRE_CYC - 1); end
      ST_HID_REL, ST_PRE: begin
        if (tmr_q == '0) begin
          st_d   = ST_IDLE;
          done_o = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      tmr_q   <= '0;
      ro_q    <= 1'b0;
      own_o   <= 1'b0;
      ras_n_o <= 1'b1;
      cas_n_o <= 1'b1;
      we_n_o  <= 1'b1;
      addr_o  <= '0;
    end else begin
      st_q    <= st_d;
      tmr_q   <= tmr_d;
      ro_q    <= ro_d;
      own_o   <= (st_d != ST_IDLE);
      ras_n_o <= !(st_d inside {ST_CBR_HOLD, ST_CBR_ACT, ST_RO_ACT, ST_HID_ACT});
      cas_n_o <= !(st_d inside {ST_CBR_SETUP, ST_CBR_HOLD, ST_HID_PRE, ST_HID_ACT, ST_HID_REL});
      we_n_o  <= 1'b1;
      addr_o  <= (ro_d && st_d != ST_IDLE) ? row_i : '0;
    end
  end
endmodule

// File: rtl/dram_refresh_ctl.sv
module dram_refresh_ctl
  import rfsh_pkg::*;
#(
  parameter int CLK_NS    = 10,
  parameter int ROWS      = 4096,
  parameter int WINDOW_NS = 64_000_000,
  parameter int MAX_PEND  = 8,
  parameter int CSR_NS    = 10,
  parameter int WSR_NS    = 10,
  parameter int CHR_NS    = 10,
  parameter int RAS_NS    = 60,
  parameter int RP_NS     = 40,
  parameter int RC_NS     = 104,
  parameter int ROW_BITS  = $clog2(ROWS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ras_only_mode,
  input  logic                hidden_ok,
  input  logic                acc_grant,
  output logic                ref_req,
  output logic                ref_urgent,
  output logic                bus_own,
  output logic                ras_n,
  output logic                cas_n,
  output logic                we_n,
  output logic [ROW_BITS-1:0] row_addr
);
  localparam int INTERVAL_CYC = WINDOW_NS / ROWS / CLK_NS;
  localparam int SETUP_CYC    = imax(ns_to_cyc(CSR_NS, CLK_NS), ns_to_cyc(WSR_NS, CLK_NS));
  localparam int HOLD_CYC     = ns_to_cyc(CHR_NS, CLK_NS);
  localparam int ACT_CYC      = imax(ns_to_cyc(RAS_NS, CLK_NS), HOLD_CYC + 1);
  localparam int PRE_CYC      = imax(ns_to_cyc(RP_NS, CLK_NS), ns_to_cyc(RC_NS, CLK_NS) - ACT_CYC);

  logic                tick, pend_nz, seq_idle, ref_done, ro_done;
  logic [ROW_BITS-1:0] row;

  assign ref_req = pend_nz && seq_idle;

  rfsh_interval_tick #(.INTERVAL_CYC(INTERVAL_CYC)) u_tick (
    .clk(clk), .rst(rst), .tick(tick)
  );

  rfsh_backlog #(.MAX_PEND(MAX_PEND)) u_backlog (
    .clk(clk), .rst(rst), .add_i(tick), .sub_i(ref_done),
    .nonzero_o(pend_nz), .full_o(ref_urgent)
  );

  rfsh_row_ctr #(.ROWS(ROWS), .ROW_BITS(ROW_BITS)) u_row (
    .clk(clk), .rst(rst), .adv_i(ro_done), .row_o(row)
  );

  rfsh_seq #(
    .ROW_BITS(ROW_BITS), .SETUP_CYC(SETUP_CYC), .HOLD_CYC(HOLD_CYC),
    .ACT_CYC(ACT_CYC), .PRE_CYC(PRE_CYC)
  ) u_seq (
    .clk(clk), .rst(rst), .start_i(ref_req && acc_grant),
    .hidden_i(hidden_ok), .ras_only_i(ras_only_mode), .row_i(row),
    .idle_o(seq_idle), .done_o(ref_done), .own_o(bus_own),
    .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n),
    .ro_done_o(ro_done), .addr_o(row_addr)
  );
endmodule

// File: rtl/dram_refresh_ctl_chk.sv
module dram_refresh_ctl_chk #(
  parameter int ROW_BITS = 12,
  parameter int ACT_MIN  = 6
) (
  input logic                clk,
  input logic                rst,
  input logic                acc_grant,
  input logic                ref_req,
  input logic                ref_urgent,
  input logic                ref_done,
  input logic                bus_own,
  input logic                ras_n,
  input logic                cas_n,
  input logic [ROW_BITS-1:0] row_addr
);
  logic [15:0] low_len;

  always_ff @(posedge clk) begin
    if (rst || ras_n)         low_len <= '0;
    else if (low_len != '1)   low_len <= low_len + 1'b1;
  end

  assert_start_after_grant_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_own) |-> $past(ref_req && acc_grant));

  assert_no_req_while_owned_R2: assert property (@(posedge clk) disable iff (rst)
    bus_own |-> !ref_req);

  assert_cas_leads_ras_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_own && $fell(ras_n) && !cas_n) |-> $past(!cas_n));

  assert_row_steady_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_own && cas_n && !ras_n && $past(!ras_n)) |-> $stable(row_addr));

  assert_ras_width_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(ras_n) |-> (low_len >= 16'(ACT_MIN)));

  assert_full_holds_R7: assert property (@(posedge clk) disable iff (rst)
    (ref_urgent && !ref_done) |=> ref_urgent);

  assert_idle_lines_R9: assert property (@(posedge clk) disable iff (rst)
    !bus_own |-> (ras_n && cas_n && row_addr == '0));
endmodule

bind dram_refresh_ctl dram_refresh_ctl_chk #(
  .ROW_BITS(ROW_BITS), .ACT_MIN(ACT_CYC)
) u_chk (
  .clk(clk), .rst(rst), .acc_grant(acc_grant), .ref_req(ref_req),
  .ref_urgent(ref_urgent), .ref_done(ref_done), .bus_own(bus_own),
  .ras_n(ras_n), .cas_n(cas_n), .row_addr(row_addr)
);

// File: tb/dram_refresh_ctl_bench.sv
module dram_refresh_ctl_bench;
  localparam int ROWS     = 16;
  localparam int RB       = 4;
  localparam int WIN_NS   = 4800;
  localparam int INTV     = 30;
  localparam int SETUP    = 1;
  localparam int HOLD     = 1;
  localparam int ACT      = 6;
  localparam int PRE      = 5;
  localparam int MAXP     = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ras_only_mode = 1'b0, hidden_ok = 1'b0, acc_grant = 1'b0;
  logic ref_req, ref_urgent, bus_own, ras_n, cas_n, we_n;
  logic [RB-1:0] row_addr;

  always #5 clk = ~clk;

  dram_refresh_ctl #(.CLK_NS(10), .ROWS(ROWS), .WINDOW_NS(WIN_NS)) u_dram_refresh_ctl (
    .clk(clk), .rst(rst), .ras_only_mode(ras_only_mode), .hidden_ok(hidden_ok),
    .acc_grant(acc_grant), .ref_req(ref_req), .ref_urgent(ref_urgent),
    .bus_own(bus_own), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .row_addr(row_addr)
  );

  int n_checks = 0, n_fail = 0;

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Behavioural reference: a queue of expected line states, one per cycle.
  typedef struct {
    bit own; bit ras; bit cas; bit we; int addr; bit hid; bit ro; bit last;
  } ent_t;

  ent_t q[$];
  ent_t cur;
  int   tc, pend, row;
  bit   tick_m, done_m;

  function automatic ent_t mk(bit own, bit ras, bit cas, int addr, bit hid, bit ro, bit last);
    ent_t e;
    e.own = own; e.ras = ras; e.cas = cas; e.we = 1'b1; e.addr = addr;
    e.hid = hid; e.ro = ro; e.last = last;
    return e;
  endfunction

  task automatic push_n(input int n, input ent_t e);
    for (int i = 0; i < n; i++) q.push_back(e);
  endtask

  always @(posedge clk) begin
    if (rst) begin
      tc = 0; pend = 0; row = 0; q.delete();
      cur = mk(0, 1, 1, 0, 0, 0, 0);
    end else begin
      tick_m = 0; done_m = 0;
      if (q.size() == 0 && pend > 0 && acc_grant) begin
        if (hidden_ok) begin
          push_n(PRE, mk(1, 1, 0, 0, 1, 0, 0));
          push_n(ACT, mk(1, 0, 0, 0, 1, 0, 0));
          push_n(PRE, mk(1, 1, 0, 0, 1, 0, 0));
          q.push_back(mk(0, 1, 1, 0, 1, 0, 1));
        end else if (ras_only_mode) begin
          push_n(1,   mk(1, 1, 1, row, 0, 1, 0));
          push_n(ACT, mk(1, 0, 1, row, 0, 1, 0));
          push_n(PRE, mk(1, 1, 1, row, 0, 1, 0));
          q.push_back(mk(0, 1, 1, 0, 0, 1, 1));
        end else begin
          push_n(SETUP,      mk(1, 1, 0, 0, 0, 0, 0));
          push_n(HOLD,       mk(1, 0, 0, 0, 0, 0, 0));
          push_n(ACT - HOLD, mk(1, 0, 1, 0, 0, 0, 0));
          push_n(PRE,        mk(1, 1, 1, 0, 0, 0, 0));
          q.push_back(mk(0, 1, 1, 0, 0, 0, 1));
        end
        cur = q.pop_front();
      end else if (q.size() != 0) begin
        cur = q.pop_front();
        if (cur.last) begin
          done_m = 1;
          if (cur.ro) row = (row + 1) % ROWS;
        end
      end
      tc++;
      if (tc == INTV) begin tc = 0; tick_m = 1; end
      if (tick_m && !done_m) begin if (pend < MAXP) pend++; end
      else if (done_m && !tick_m) pend--;
    end
  end

  // Compare every cycle, away from the active edge.
  always @(negedge clk) begin
    if (!rst) begin
      check("R1", "ref_req", int'(ref_req), int'(pend > 0 && q.size() == 0));
      check("R7", "ref_urgent", int'(ref_urgent), int'(pend == MAXP));
      check("R2", "bus_own", int'(bus_own), int'(cur.own));
      check("R6", "ras_n", int'(ras_n), int'(cur.ras));
      check(cur.hid ? "R8" : "R3", "cas_n", int'(cas_n), int'(cur.cas));
      check("R4", "we_n", int'(we_n), int'(cur.we));
      check("R5", "row_addr", int'(row_addr), cur.addr);
    end
  end

  int cyc = 0;
  bit finished = 0;

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      summary();
    end
  end

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  int wraps, prev_addr, hid_cas_high, hid_seen;

  initial begin
    wait_cyc(3);
    rst = 1'b0;
    @(negedge clk);
    // R9: reset state
    check("R9", "reset ref_req", int'(ref_req), 0);
    check("R9", "reset bus_own", int'(bus_own), 0);
    check("R9", "reset lines", int'({ras_n, cas_n, we_n}), 7);
    check("R9", "reset row_addr", int'(row_addr), 0);

    // R1: first owed refresh after exactly INTV cycles
    wait_cyc(INTV - 2);
    check("R1", "no request before interval", int'(ref_req), 0);
    wait_cyc(1);
    check("R1", "request after interval", int'(ref_req), 1);

    // R7: fill the backlog and let extra intervals pass
    wait_cyc(INTV * (MAXP + 2));
    check("R7", "urgent after saturation", int'(ref_urgent), 1);

    // R3/R10: drain with CBR, toggle inputs mid-refresh
    acc_grant = 1'b1;
    wait_cyc(3);
    ras_only_mode = 1'b1; hidden_ok = 1'b1; acc_grant = 1'b0;
    wait_cyc(2);
    check("R10", "cas_n after mid-run mode change", int'(cas_n), 1);
    check("R10", "row_addr after mid-run mode change", int'(row_addr), 0);
    ras_only_mode = 1'b0; hidden_ok = 1'b0; acc_grant = 1'b1;
    wait_cyc(150);
    check("R7", "urgent cleared after draining", int'(ref_urgent), 0);

    // R5: RAS-only refreshes, row wraps
    ras_only_mode = 1'b1;
    wraps = 0; prev_addr = 0;
    for (int i = 0; i < INTV * 22; i++) begin
      @(negedge clk);
      if (bus_own && !ras_n) begin
        if (prev_addr == ROWS - 1 && row_addr == 0) wraps++;
        prev_addr = row_addr;
      end
    end
    check("R5", "row counter wrapped", int'(wraps > 0), 1);
    ras_only_mode = 1'b0;
    wait_cyc(20);

    // R8: hidden refreshes
    hidden_ok = 1'b1;
    hid_cas_high = 0; hid_seen = 0;
    for (int i = 0; i < INTV * 6; i++) begin
      @(negedge clk);
      if (bus_own && !ras_n) hid_seen++;
      if (bus_own && cas_n) hid_cas_high++;
    end
    check("R8", "hidden refresh ran", int'(hid_seen > 0), 1);
    check("R8", "cas_n high cycles while hidden", hid_cas_high, 0);
    hidden_ok = 1'b0;
    wait_cyc(20);

    // Mixed random traffic
    for (int i = 0; i < 2500; i++) begin
      @(negedge clk);
      acc_grant = ($urandom % 4) != 0 ? ($urandom % 2) : 1'b0;
      if (($urandom % 16) == 0) ras_only_mode = $urandom % 2;
      if (($urandom % 16) == 0) hidden_ok = $urandom % 2;
    end
    acc_grant = 1'b0;
    wait_cyc(20);
    summary();
  end
endmodule